// File: doc/BRIEF.md
# Two-Level Local-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken by looking at what that same branch did the last few times it ran. A front end presents a branch address on the lookup port and gets a taken or not-taken bit back in the same cycle. When the branch resolves later, the back end presents the address again on the update port together with the real outcome. The block then trains its tables.

The first level is a table of per-branch outcome shift registers, selected by a slice of the branch address. The second level is a table of two-bit saturating counters. Its entry is chosen by the history pattern read from the first level, not by the address. A branch with a short repeating pattern therefore trains one counter for each position in its pattern, and each of those counters becomes confident on its own. Both table sizes are parameters.

Top module: `lhist_predictor`

## Requirements
- R1: The history entry used by either port is selected by address bits [ADDR_LSB+IDX_W-1:ADDR_LSB] (defaults: bits [7:2]). Addresses that differ only outside that slice share one history entry.
- R2: On an update with upd_valid high, the selected history register shifts left by one. The resolved outcome enters bit 0 (1 = taken, 0 = not taken) and the oldest bit leaves at the top.
- R3: The counter used for a prediction is the one whose index equals the full HIST_W-bit history of the selected entry. On an update, the counter trained is the one indexed by that entry's history as it stood before the shift in the same cycle.
- R4: pred_taken is 1 when the selected counter holds 2 or 3, and 0 when it holds 0 or 1.
- R5: A counter trained by a taken outcome goes up by one, and one trained by a not-taken outcome goes down by one. It stays at 3 or at 0 rather than wrapping.
- R6: A synchronous active-high reset clears every history register to 0 and sets every counter to 1, so every lookup after reset predicts not taken.
- R7: pred_taken follows pred_addr combinationally. Training takes effect at the next rising clock edge, so a lookup in the same cycle as an update to the same entry sees the old history and counter.
- R8: While upd_valid is low, upd_addr and upd_taken change no state, and every later prediction is as if that cycle had not happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_addr | input | ADDR_W | Branch address being looked up |
| pred_taken | output | 1 | Predicted direction for pred_addr, 1 = taken |
| upd_valid | input | 1 | Update request this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest case to reach from the ports is a counter pinned at a saturation limit for a history pattern other than all ones or all zeros. To get there, one entry has to repeat the same short outcome pattern many times, so the same non-trivial history recurs and its counter keeps being pushed the same way. The random phase assigns each history entry a fixed periodic outcome pattern of period 2 to 5 and reaches the entry through several aliased addresses. Mixed patterns therefore train their counters all the way to both limits while other entries keep changing. Directed sequences cover the reset state, the aliasing of addresses, a lookup and update to the same entry in one cycle, and idle cycles that carry random update address and outcome values.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
  typedef logic [1:0] ctr2_t;
  localparam ctr2_t CTR_INIT = 2'd1;

  function automatic ctr2_t ctr_step(input ctr2_t c, input logic taken);
    ctr2_t r;
    if (taken) r = (c == 2'd3) ? c : c + 2'd1;
    else       r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_taken,
  output logic [HIST_W-1:0] wr_hist_old,
  output logic [HIST_W-1:0] wr_hist_new
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [ENTRIES];

  assign rd_hist     = hist_q[rd_idx];
  assign wr_hist_old = hist_q[wr_idx];
  assign wr_hist_new = {wr_hist_old[HIST_W-2:0], wr_taken};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[wr_idx] <= wr_hist_new;
    end
  end
endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table
  import lhp_pkg::*;
#(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HIST_W-1:0] rd_idx,
  output ctr2_t             rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken,
  output ctr2_t             wr_ctr_old,
  output ctr2_t             wr_ctr_new
);
  localparam int DEPTH = 1 << HIST_W;

  ctr2_t ctr_q [DEPTH];

  assign rd_ctr     = ctr_q[rd_idx];
  assign wr_ctr_old = ctr_q[wr_idx];
  assign wr_ctr_new = ctr_step(wr_ctr_old, wr_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_ctr_new;
    end
  end
endmodule

// File: rtl/lhist_predictor.sv
module lhist_predictor
  import lhp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ADDR_LSB = 2,
  parameter int IDX_W    = 6,
  parameter int HIST_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pred_addr,
  output logic              pred_taken,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken
);
  localparam int IDX_HI = ADDR_LSB + IDX_W - 1;

  logic [IDX_W-1:0]  pred_idx, upd_idx;
  logic [HIST_W-1:0] pred_hist, upd_hist_old, upd_hist_new;
  ctr2_t             pred_ctr, upd_ctr_old, upd_ctr_new;
  logic              unused_addr_bits;

  assign pred_idx         = pred_addr[IDX_HI:ADDR_LSB];
  assign upd_idx          = upd_addr[IDX_HI:ADDR_LSB];
  assign unused_addr_bits = ^{pred_addr, upd_addr};

  lhp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst),
    .rd_idx(pred_idx), .rd_hist(pred_hist),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken),
    .wr_hist_old(upd_hist_old), .wr_hist_new(upd_hist_new)
  );

  lhp_ctr_table #(.HIST_W(HIST_W)) u_ctrs (
    .clk(clk), .rst(rst),
    .rd_idx(pred_hist), .rd_ctr(pred_ctr),
    .wr_en(upd_valid), .wr_idx(upd_hist_old), .wr_taken(upd_taken),
    .wr_ctr_old(upd_ctr_old), .wr_ctr_new(upd_ctr_new)
  );

  assign pred_taken = pred_ctr[1];
endmodule

// File: rtl/lhist_predictor_chk.sv
module lhist_predictor_chk #(
  parameter int ADDR_W = 32,
  parameter int HIST_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] pred_addr,
  input logic              pred_taken,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] upd_hist_old,
  input logic [HIST_W-1:0] upd_hist_new,
  input logic [1:0]        upd_ctr_old,
  input logic [1:0]        upd_ctr_new
);
  // R6: the cycle after reset every lookup is not taken
  p_reset_weak_r6: assert property (@(posedge clk) rst |=> !pred_taken);

  // R5: a taken outcome never lowers a counter (catches 3 -> 0 wrap)
  p_taken_no_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken) |-> (upd_ctr_new >= upd_ctr_old));

  // R5: a not-taken outcome never raises a counter (catches 0 -> 3 wrap)
  p_nt_no_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken) |-> (upd_ctr_new <= upd_ctr_old));

  // R5: a counter moves by at most one step
  p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> ($countones(upd_ctr_new ^ upd_ctr_old) <= 2 &&
                   ((upd_ctr_new == upd_ctr_old) || (upd_ctr_new == upd_ctr_old + 2'd1) ||
                    (upd_ctr_new == upd_ctr_old - 2'd1))));

  // R2: the newest outcome lands in bit 0 and older bits move up
  p_hist_shift_r2: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (upd_hist_new[0] == upd_taken &&
                   upd_hist_new[HIST_W-1:1] == upd_hist_old[HIST_W-2:0]));

  // R8: without an update the prediction for a held address holds
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upd_valid) && $stable(pred_addr)) |-> $stable(pred_taken));
endmodule

bind lhist_predictor lhist_predictor_chk #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .pred_addr(pred_addr), .pred_taken(pred_taken),
  .upd_valid(upd_valid), .upd_taken(upd_taken),
  .upd_hist_old(upd_hist_old), .upd_hist_new(upd_hist_new),
  .upd_ctr_old(upd_ctr_old), .upd_ctr_new(upd_ctr_new)
);

// File: tb/lhist_predictor_tb.sv
`timescale 1ns/1ps
module lhist_predictor_tb;
  localparam int ADDR_W = 32, ADDR_LSB = 2, IDX_W = 6, HIST_W = 6;
  localparam int ENT = 1 << IDX_W, DEP = 1 << HIST_W;

  logic clk = 1'b0, rst = 1'b1;
  logic [ADDR_W-1:0] pred_addr = '0, upd_addr = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic pred_taken;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [HIST_W-1:0] hist_m [ENT];
  logic [1:0]        ctr_m  [DEP];

  always #2.5 clk = ~clk;

  lhist_predictor #(.ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W))
    u_dut (.clk(clk), .rst(rst), .pred_addr(pred_addr), .pred_taken(pred_taken),
           .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken));

  function automatic int idx_of(input logic [ADDR_W-1:0] a);
    return int'(a[ADDR_LSB+IDX_W-1:ADDR_LSB]);
  endfunction

  // R4: taken when the counter selected by the entry's history is 2 or 3
  function automatic logic exp_pred(input logic [ADDR_W-1:0] a);
    return ctr_m[hist_m[idx_of(a)]] >= 2'd2;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < ENT; i++) hist_m[i] = '0;
    for (int i = 0; i < DEP; i++) ctr_m[i] = 2'd1;
  endtask

  task automatic model_update(input logic [ADDR_W-1:0] a, input logic t);
    int e = idx_of(a);
    logic [HIST_W-1:0] h = hist_m[e];
    if (t && ctr_m[h] != 2'd3) ctr_m[h] = ctr_m[h] + 2'd1;
    if (!t && ctr_m[h] != 2'd0) ctr_m[h] = ctr_m[h] - 2'd1;
    hist_m[e] = {h[HIST_W-2:0], t};
  endtask

  // One cycle: drive at the falling edge, check the prediction, then the rising edge.
  task automatic step(input logic [ADDR_W-1:0] pa, input logic uv,
                      input logic [ADDR_W-1:0] ua, input logic ut, input string tag);
    logic e;
    @(negedge clk);
    pred_addr = pa; upd_valid = uv; upd_addr = ua; upd_taken = ut;
    #1;
    e = exp_pred(pa);
    checks++;
    if (pred_taken !== e) begin
      errors++;
      $display("FAIL %s addr=%h actual=%0b expected=%0b", tag, pa, pred_taken, e);
    end
    @(posedge clk);
    if (uv) model_update(ua, ut);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a, b;
    int pat_per [4];
    int pat_bits [4];
    int pos [4];
    void'($urandom(32'd20240517));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R6: every entry predicts not taken after reset
    for (int i = 0; i < 8; i++) step(i * 4 * 7, 1'b0, '0, 1'b0, "R6");

    // R3: train entry 1 once (hist 0 -> counter 0 becomes 2), then entry 2 still uses counter 0
    a = 32'h0000_0004; b = 32'h0000_0008;
    step(a, 1'b1, a, 1'b1, "R7");
    step(a, 1'b0, '0, 1'b0, "R3");   // entry 1 history now 1, counter 1 = 1
    step(b, 1'b0, '0, 1'b0, "R3");   // entry 2 history 0, counter 0 = 2

    // R7: update entry 2 and look it up in the same cycle
    step(b, 1'b1, b, 1'b1, "R7");
    step(b, 1'b0, '0, 1'b0, "R7");

    // R1: an address differing above the index slice shares entry 1
    step(32'hABCD_0004, 1'b0, '0, 1'b0, "R1");
    step(32'h0000_0107, 1'b1, 32'h1234_5605, 1'b0, "R1");
    step(32'h0000_0004, 1'b0, '0, 1'b0, "R1");

    // R5/R2: drive one entry taken many times, then back down past zero
    a = 32'h0000_0040;
    for (int i = 0; i < 12; i++) step(a, 1'b1, a, 1'b1, "R5");
    for (int i = 0; i < 4; i++)  step(a, 1'b1, a, 1'b1, "R2");
    for (int i = 0; i < 12; i++) step(a, 1'b1, a, 1'b0, "R5");
    step(a, 1'b0, '0, 1'b0, "R4");

    // R8: idle cycles with noise on the update fields, then look around
    for (int i = 0; i < 20; i++) step($urandom, 1'b0, $urandom, 1'($urandom), "R8");
    for (int i = 0; i < ENT; i++) step(i << ADDR_LSB, 1'b0, $urandom, 1'b1, "R8");

    // R3: random phase, periodic patterns per entry, aliased addresses
    for (int k = 0; k < 4; k++) begin
      pat_per[k] = 2 + int'($urandom % 4);
      pat_bits[k] = int'($urandom);
      pos[k] = 0;
    end
    for (int n = 0; n < 4000; n++) begin
      int k = int'($urandom % 4);
      logic t = pat_bits[k][pos[k]];
      logic [ADDR_W-1:0] ua = {$urandom} & ~(32'(ENT - 1) << ADDR_LSB) | (32'(k) << ADDR_LSB);
      logic [ADDR_W-1:0] pa = {$urandom} & ~(32'(ENT - 1) << ADDR_LSB) |
                              (32'($urandom % 4) << ADDR_LSB);
      logic uv = ($urandom % 8) != 0;
      step(pa, uv, ua, t, "R3");
      if (uv) pos[k] = (pos[k] + 1) % pat_per[k];
    end

    // R6: reset mid-run restores the weak not-taken state
    @(negedge clk); rst = 1'b1; upd_valid = 1'b0;
    @(posedge clk); model_reset();
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) step(i << ADDR_LSB, 1'b0, '0, 1'b0, "R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule